// File: doc/BRIEF.md
# Bandwidth Register Access Verdict Unit

This unit judges each attempt to read or write a system register that belongs to the per-core memory-bandwidth limiting scheme. Every cycle it samples the requesting privilege level (0 to 3), the five encoding fields of the register, a flag that says whether bandwidth limiting exists in this core, and the trap-disable bit taken from the top-level bandwidth control word. One clock later it presents a verdict:
- access allowed;
- undefined instruction;
- trap to level 3 with a syndrome class;
- hand the decision to the lower-priority level-2 trap logic.

The unit covers two groups of registers. One is the top-level bandwidth control register, which only level 3 may touch. The other is a parameterised list of lower-level bandwidth registers, whose level-1 accesses the trap-disable bit can redirect to level 3. An encoding in neither group yields no verdict, and other decoders handle it. Register storage and exception entry sit elsewhere.

Top module: `sr_trap_check`

## Requirements
- R1: While reset is held, and in the first verdict cycle after release, all four verdict outputs and `syn_class` are 0.
- R2: At most one of `allow`, `undef`, `trap_el3`, `pass_lower` is 1 in any cycle. All four are 0 for an encoding that is neither the top-level register nor in the governed list.
- R3: When `feat_present` is 0, an access to the top-level register or to any governed register is undefined, at every privilege level.
- R4: Encodings are packed as {op0[1:0], op1[2:0], crn[3:0], crm[3:0], op2[2:0]}. The top-level register is op0=3, op1=6, crn=10, crm=5, op2=4 (packed 16'hF52C). With the feature present, it is undefined from levels 0, 1 and 2 and allowed from level 3.
- R5: With the feature present, a level-1 access to a governed register while `ntrap_lower` is 0 raises `trap_el3` with `syn_class` = 6'h18.
- R6: With the feature present, a governed access raises `pass_lower` when it comes from level 2, or from level 1 with `ntrap_lower` = 1. The level-3 trap therefore always wins over the level-2 check.
- R7: With the feature present, a governed register is undefined from level 0 and allowed from level 3, whatever the value of `ntrap_lower`.
- R8: `syn_class` is 0 whenever `trap_el3` is 0.
- R9: The verdict for the inputs sampled at one rising edge appears after that edge and holds for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| el | input | 2 | Current privilege level, 0 to 3 |
| op0 | input | 2 | Encoding field op0 |
| op1 | input | 3 | Encoding field op1 |
| crn | input | 4 | Encoding field CRn |
| crm | input | 4 | Encoding field CRm |
| op2 | input | 3 | Encoding field op2 |
| feat_present | input | 1 | Bandwidth limiting is implemented |
| ntrap_lower | input | 1 | Trap-disable bit of the top-level control word |
| allow | output | 1 | Access may proceed |
| undef | output | 1 | Undefined-instruction exception |
| trap_el3 | output | 1 | Trap to level 3 |
| pass_lower | output | 1 | Consult the level-2 trap logic |
| syn_class | output | 6 | Syndrome class, valid with `trap_el3` |

## Verification
The main patterns are full sweeps over privilege level, trap-disable bit and feature flag, run for the top-level register and for each governed encoding. These sweeps separate the feature-absent priority from the level rule, and the trap from the level-2 hand-off. Near-miss encodings, each one field away from a handled register, show that the matcher compares every field and that unhandled accesses give no verdict. Back-to-back changes of input show that each verdict holds for one cycle and does not linger.

// File: rtl/sr_trap_pkg.sv
package sr_trap_pkg;
  localparam int ENC_W = 16;
  localparam int SYN_W = 6;

  typedef logic [ENC_W-1:0] enc_t;

  typedef enum logic [2:0] {
    V_NONE  = 3'd0,
    V_ALLOW = 3'd1,
    V_UNDEF = 3'd2,
    V_TRAP  = 3'd3,
    V_PASS  = 3'd4
  } verdict_e;

  localparam enc_t TOP_ENC = 16'hF52C;
  localparam logic [SYN_W-1:0] TRAP_SYN = 6'h18;

  function automatic enc_t pack_enc(input logic [1:0] o0, input logic [2:0] o1,
                                    input logic [3:0] n, input logic [3:0] m,
                                    input logic [2:0] o2);
    return {o0, o1, n, m, o2};
  endfunction
endpackage

// File: rtl/sr_enc_match.sv
module sr_enc_match
  import sr_trap_pkg::*;
#(
  parameter int NUM_GOV = 6,
  parameter logic [NUM_GOV*ENC_W-1:0] GOV_LIST = '0
) (
  input  enc_t enc,
  output logic is_top,
  output logic is_gov
);
  logic [NUM_GOV-1:0] hit;

  for (genvar g = 0; g < NUM_GOV; g++) begin : g_cmp
    assign hit[g] = (enc == GOV_LIST[g*ENC_W +: ENC_W]);
  end

  assign is_top = (enc == TOP_ENC);
  assign is_gov = |hit;
endmodule

// File: rtl/sr_verdict.sv
module sr_verdict
  import sr_trap_pkg::*;
(
  input  logic       is_top,
  input  logic       is_gov,
  input  logic [1:0] el,
  input  logic       feat_present,
  input  logic       ntrap_lower,
  output verdict_e   verdict
);
  always_comb begin
    verdict = V_NONE;
    if (is_top || is_gov) begin
      if (!feat_present) begin
        verdict = V_UNDEF;
      end else if (is_top) begin
        verdict = (el == 2'd3) ? V_ALLOW : V_UNDEF;
      end else begin
        unique case (el)
          2'd0: verdict = V_UNDEF;
          2'd1: verdict = ntrap_lower ? V_PASS : V_TRAP;
          2'd2: verdict = V_PASS;
          default: verdict = V_ALLOW;
        endcase
      end
    end
  end
endmodule

// File: rtl/sr_trap_check.sv
module sr_trap_check
  import sr_trap_pkg::*;
#(
  parameter int NUM_GOV = 6,
  parameter logic [NUM_GOV*ENC_W-1:0] GOV_LIST =
    {16'hE52E, 16'hE52C, 16'hC52B, 16'hC52A, 16'hC529, 16'hC528}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] el,
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  input  logic       feat_present,
  input  logic       ntrap_lower,
  output logic       allow,
  output logic       undef,
  output logic       trap_el3,
  output logic       pass_lower,
  output logic [SYN_W-1:0] syn_class
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  enc_t     enc;
  logic     is_top, is_gov;
  verdict_e verdict;

  assign enc = pack_enc(op0, op1, crn, crm, op2);

  sr_enc_match #(.NUM_GOV(NUM_GOV), .GOV_LIST(GOV_LIST)) u_match (
    .enc(enc), .is_top(is_top), .is_gov(is_gov)
  );

  sr_verdict u_verdict (
    .is_top(is_top), .is_gov(is_gov), .el(el),
    .feat_present(feat_present), .ntrap_lower(ntrap_lower), .verdict(verdict)
  );

  logic             allow_d, undef_d, trap_d, pass_d;
  logic [SYN_W-1:0] syn_d;
  logic             out_en;

  always_comb begin
    allow_d = (verdict == V_ALLOW);
    undef_d = (verdict == V_UNDEF);
    trap_d  = (verdict == V_TRAP);
    pass_d  = (verdict == V_PASS);
    syn_d   = trap_d ? TRAP_SYN : '0;
  end

  assign out_en = 1'b1;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      allow      <= 1'b0;
      undef      <= 1'b0;
      trap_el3   <= 1'b0;
      pass_lower <= 1'b0;
      syn_class  <= '0;
    end else if (out_en) begin
      allow      <= allow_d;
      undef      <= undef_d;
      trap_el3   <= trap_d;
      pass_lower <= pass_d;
      syn_class  <= syn_d;
    end
  end
endmodule

// File: rtl/sr_trap_check_sva.sv
module sr_trap_check_sva
  import sr_trap_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] el,
  input logic [1:0] op0,
  input logic [2:0] op1,
  input logic [3:0] crn,
  input logic [3:0] crm,
  input logic [2:0] op2,
  input logic       feat_present,
  input logic       ntrap_lower,
  input logic       allow,
  input logic       undef,
  input logic       trap_el3,
  input logic       pass_lower,
  input logic [SYN_W-1:0] syn_class
);
  logic top_hit;
  logic [1:0] up_q;
  assign top_hit = (op0 == 2'd3) && (op1 == 3'd6) && (crn == 4'd10) &&
                   (crm == 4'd5) && (op2 == 3'd4);

  // counts cycles of reset release so properties look only at settled verdicts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 2'd0;
    else if (up_q != 2'd3) up_q <= up_q + 2'd1;
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({allow, undef, trap_el3, pass_lower}));

  a_r3_feat_absent: assert property (@(posedge clk) disable iff (!rst_n || up_q != 2'd3)
    (top_hit && !feat_present) |=> undef);

  a_r4_top_low_el: assert property (@(posedge clk) disable iff (!rst_n || up_q != 2'd3)
    (top_hit && feat_present && el != 2'd3) |=> undef);

  a_r4_top_el3: assert property (@(posedge clk) disable iff (!rst_n || up_q != 2'd3)
    (top_hit && feat_present && el == 2'd3) |=> allow);

  a_r5_trap_cause: assert property (@(posedge clk) disable iff (!rst_n || up_q != 2'd3)
    trap_el3 |-> ($past(el) == 2'd1 && !$past(ntrap_lower) && $past(feat_present)
                  && syn_class == 6'h18));

  a_r8_syn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_el3 |-> (syn_class == '0));

  a_r6_pass_level: assert property (@(posedge clk) disable iff (!rst_n || up_q != 2'd3)
    pass_lower |-> ($past(el) == 2'd1 || $past(el) == 2'd2));
endmodule

bind sr_trap_check sr_trap_check_sva u_sva (
  .clk(clk), .rst_n(rst_n), .el(el), .op0(op0), .op1(op1), .crn(crn), .crm(crm),
  .op2(op2), .feat_present(feat_present), .ntrap_lower(ntrap_lower),
  .allow(allow), .undef(undef), .trap_el3(trap_el3), .pass_lower(pass_lower),
  .syn_class(syn_class)
);

// File: tb/sim_sr_trap_check.sv
`timescale 1ns/1ps
module sim_sr_trap_check;
  logic clk, rst_n;
  logic [1:0] el, op0;
  logic [2:0] op1, op2;
  logic [3:0] crn, crm;
  logic feat_present, ntrap_lower;
  logic allow, undef, trap_el3, pass_lower;
  logic [5:0] syn_class;

  int total = 0;
  int bad = 0;

  sr_trap_check u0 (
    .clk(clk), .rst_n(rst_n), .el(el), .op0(op0), .op1(op1), .crn(crn), .crm(crm),
    .op2(op2), .feat_present(feat_present), .ntrap_lower(ntrap_lower),
    .allow(allow), .undef(undef), .trap_el3(trap_el3), .pass_lower(pass_lower),
    .syn_class(syn_class)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  localparam logic [15:0] TOP = 16'hF52C;
  logic [15:0] gov [6];
  initial begin
    gov[0] = 16'hC528; gov[1] = 16'hC529; gov[2] = 16'hC52A;
    gov[3] = 16'hC52B; gov[4] = 16'hE52C; gov[5] = 16'hE52E;
  end

  // expected {allow, undef, trap, pass, syn}
  function automatic logic [9:0] ref_out(input logic [15:0] e, input logic [1:0] l,
                                         input logic f, input logic nt);
    logic g;
    g = 1'b0;
    for (int i = 0; i < 6; i++) if (e == gov[i]) g = 1'b1;
    if (e != TOP && !g) return 10'b0;
    if (!f) return {4'b0100, 6'h0};
    if (e == TOP) return (l == 2'd3) ? {4'b1000, 6'h0} : {4'b0100, 6'h0};
    case (l)
      2'd0: return {4'b0100, 6'h0};
      2'd1: return nt ? {4'b0001, 6'h0} : {4'b0010, 6'h18};
      2'd2: return {4'b0001, 6'h0};
      default: return {4'b1000, 6'h0};
    endcase
  endfunction

  task automatic drive(input logic [15:0] e, input logic [1:0] l, input logic f,
                       input logic nt);
    {op0, op1, crn, crm, op2} = e;
    el = l; feat_present = f; ntrap_lower = nt;
  endtask

  task automatic compare(input string req, input logic [9:0] exp);
    logic [9:0] act;
    act = {allow, undef, trap_el3, pass_lower, syn_class};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b enc=%h el=%0d f=%0d nt=%0d", req, act, exp,
               {op0, op1, crn, crm, op2}, el, feat_present, ntrap_lower);
    end
  endtask

  // apply at negedge, sample just after next posedge
  task automatic probe(input string req, input logic [15:0] e, input logic [1:0] l,
                       input logic f, input logic nt);
    @(negedge clk);
    drive(e, l, f, nt);
    @(posedge clk); #1;
    compare(req, ref_out(e, l, f, nt));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive(TOP, 2'd3, 1'b1, 1'b1);
    repeat (3) @(posedge clk);
    #1 compare("R1 held", 10'b0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 compare("R1 first release", 10'b0);
    repeat (3) @(posedge clk);
  endtask

  task automatic t_top_sweep();
    for (int l = 0; l < 4; l++)
      for (int f = 0; f < 2; f++)
        for (int nt = 0; nt < 2; nt++)
          probe(f == 0 ? "R3 top absent" : "R4 top level", TOP, l[1:0], f[0], nt[0]);
  endtask

  task automatic t_gov_sweep();
    for (int i = 0; i < 6; i++)
      for (int l = 0; l < 4; l++)
        for (int f = 0; f < 2; f++)
          for (int nt = 0; nt < 2; nt++)
            probe(f == 0 ? "R3 gov absent" :
                  (l == 1 && nt == 0) ? "R5 R8 gov trap" :
                  (l == 1 || l == 2) ? "R6 gov pass" : "R7 gov el0/el3",
                  gov[i], l[1:0], f[0], nt[0]);
  endtask

  task automatic t_unhandled();
    logic [15:0] near [6];
    near[0] = TOP ^ 16'h0001; near[1] = TOP ^ 16'h0008; near[2] = TOP ^ 16'h0080;
    near[3] = TOP ^ 16'h0800; near[4] = TOP ^ 16'h4000; near[5] = 16'hC52C;
    for (int i = 0; i < 6; i++)
      for (int l = 0; l < 4; l++)
        probe("R2 unhandled", near[i], l[1:0], 1'b1, 1'b0);
  endtask

  task automatic t_latency();
    // trap then allow back to back: trap must last one cycle only
    probe("R9 trap cycle", gov[0], 2'd1, 1'b1, 1'b0);
    probe("R9 next verdict", TOP, 2'd3, 1'b1, 1'b0);
    @(negedge clk);
    drive(16'h0000, 2'd1, 1'b1, 1'b0);
    #1 compare("R9 holds until edge", {4'b1000, 6'h0});
    @(posedge clk); #1 compare("R9 R2 clears", 10'b0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_top_sweep();
        t_gov_sweep();
        t_unhandled();
        t_latency();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule